// File: doc/BRIEF.md
# Dimension-Order Output Port Selector for a 2D Mesh Router

This block chooses the output port for each packet header entering one router of a square two-dimensional mesh. It takes the packet's destination coordinates and the router's own coordinates. It forms a signed offset in each dimension and asks for exactly one of five ports: the two X-direction neighbours, the two Y-direction neighbours, or delivery to the attached processor.

The X dimension is always resolved first. A packet moves in Y only once its X offset is zero, so no route ever turns from Y back into X. This removes the cycles in the channel dependences that could otherwise deadlock the mesh.

Headers arrive on a valid/ready handshake. The decision is registered, so it appears one clock after the header is accepted. It is held, together with its valid flag, until the downstream side takes it. Buffering, arbitration, crossbar switching and credit flow control belong to neighbouring blocks.

Top module: `mesh_route_dor`

## Requirements
- R1: When the destination X is less than the local X, the selected port is west, bit 0 of `sel_port`.
- R2: When the destination X is greater than the local X, the selected port is east, bit 1 of `sel_port`, whatever the Y coordinates are.
- R3: When the X coordinates are equal and the destination Y is less than the local Y, the selected port is south, bit 2 of `sel_port`.
- R4: When the X coordinates are equal and the destination Y is greater than the local Y, the selected port is north, bit 3 of `sel_port`.
- R5: When both coordinates are equal, the selected port is the local processor, bit 4 of `sel_port`.
- R6: Whenever `sel_valid` is high, exactly one bit of `sel_port` is set.
- R7: A header accepted at a clock edge (`hdr_valid` and `hdr_ready` both high) shows its decision on `sel_port` with `sel_valid` high directly after that edge.
- R8: While `sel_valid` is high and `sel_ready` is low, `hdr_ready` is low, and `sel_port` and `sel_valid` keep their values across the next edge.
- R9: `hdr_ready` is high whenever no decision is pending or the pending decision is being taken (`sel_ready` high).
- R10: After reset, `sel_valid` is low and `hdr_ready` is high.
- R11: When a pending decision is taken and no header is offered, `sel_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| here_x | input | clog2(MESH_K) | X coordinate of this router |
| here_y | input | clog2(MESH_K) | Y coordinate of this router |
| hdr_valid | input | 1 | A header is offered |
| hdr_ready | output | 1 | The block can take a header this cycle |
| dst_x | input | clog2(MESH_K) | Destination X of the offered header |
| dst_y | input | clog2(MESH_K) | Destination Y of the offered header |
| sel_valid | output | 1 | A port decision is pending |
| sel_ready | input | 1 | The downstream side takes the pending decision |
| sel_port | output | 5 | One-hot port request {local, north, south, east, west} |

## Verification
The hardest case to reach is a stall that lands while a different header is already waiting at the input. The pending decision must stay frozen, and the waiting header must not slip in. The bench sets up this case on purpose. It accepts an eastbound header, drops `sel_ready`, and then offers a southbound header for several cycles. It checks that the east request and a low `hdr_ready` persist, and that the south decision appears only after the release. Apart from this, the bench sweeps every pair of router and destination coordinates in a 4-by-4 mesh. This covers each sign combination of the two offsets, including the edge and corner rows where an offset reaches its largest magnitude.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

   localparam int PORT_N = 5;

   // Bit positions of the one-hot port request; the switch decodes these.
   localparam int P_WEST  = 0;
   localparam int P_EAST  = 1;
   localparam int P_SOUTH = 2;
   localparam int P_NORTH = 3;
   localparam int P_LOCAL = 4;

   typedef logic [PORT_N-1:0] port_sel_t;

   // Direction sign of one offset dimension.
   typedef struct packed {
      logic neg;
      logic pos;
   } dim_sign_t;

endpackage

// File: rtl/mesh_route_offset.sv
// Signed offset of one mesh dimension, reduced to its sign.
module mesh_route_offset #(
   parameter int CW = 2
) (
   input  logic [CW-1:0]               dst_c,
   input  logic [CW-1:0]               here_c,
   output mesh_route_pkg::dim_sign_t   sign_o
);
   localparam int OW = CW + 1;

   logic signed [OW-1:0] delta;

   always_comb begin
      delta       = $signed({1'b0, dst_c}) - $signed({1'b0, here_c});
      sign_o.neg  = delta[OW-1];
      sign_o.pos  = !delta[OW-1] && (delta != '0);
   end
endmodule

// File: rtl/mesh_route_decide.sv
// X-first port choice from the two offset signs.
module mesh_route_decide
   import mesh_route_pkg::*;
(
   input  dim_sign_t  x_sign,
   input  dim_sign_t  y_sign,
   output port_sel_t  port_o
);
   always_comb begin
      port_o = '0;
      if (x_sign.neg)
         port_o[P_WEST] = 1'b1;
      else if (x_sign.pos)
         port_o[P_EAST] = 1'b1;
      else if (y_sign.neg)
         port_o[P_SOUTH] = 1'b1;
      else if (y_sign.pos)
         port_o[P_NORTH] = 1'b1;
      else
         port_o[P_LOCAL] = 1'b1;
   end
endmodule

// File: rtl/mesh_route_stage.sv
// One-entry registered output with a valid/ready handshake on both sides.
module mesh_route_stage #(
   parameter int W = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [W-1:0]  in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [W-1:0]  out_data
);
   logic          full_q;
   logic [W-1:0]  data_q;
   logic          load;

   always_comb begin
      in_ready = !full_q || out_ready;
      load     = in_valid && in_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (load) begin
            full_q <= 1'b1;
            data_q <= in_data;
         end else if (out_ready) begin
            full_q <= 1'b0;
         end
      end
   end

   assign out_valid = full_q;
   assign out_data  = data_q;
endmodule

// File: rtl/mesh_route_dor.sv
// Dimension-order output port selector for one router of a K-by-K mesh.
module mesh_route_dor
   import mesh_route_pkg::*;
#(
   parameter int MESH_K = 4,
   localparam int CW = (MESH_K < 2) ? 1 : $clog2(MESH_K)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CW-1:0]       here_x,
   input  logic [CW-1:0]       here_y,
   input  logic                hdr_valid,
   output logic                hdr_ready,
   input  logic [CW-1:0]       dst_x,
   input  logic [CW-1:0]       dst_y,
   output logic                sel_valid,
   input  logic                sel_ready,
   output logic [PORT_N-1:0]   sel_port
);
   localparam int NDIM = 2;

   if (MESH_K < 2) begin : g_bad_k
      $error("mesh_route_dor: MESH_K must be at least 2");
   end

   logic [CW-1:0] dst_c  [NDIM];
   logic [CW-1:0] here_c [NDIM];
   dim_sign_t     sgn    [NDIM];
   port_sel_t     port_next;

   always_comb begin
      dst_c[0]  = dst_x;
      dst_c[1]  = dst_y;
      here_c[0] = here_x;
      here_c[1] = here_y;
   end

   for (genvar d = 0; d < NDIM; d++) begin : g_dim
      mesh_route_offset #(.CW(CW)) u_off (
         .dst_c  (dst_c[d]),
         .here_c (here_c[d]),
         .sign_o (sgn[d])
      );
   end

   mesh_route_decide u_decide (
      .x_sign (sgn[0]),
      .y_sign (sgn[1]),
      .port_o (port_next)
   );

   mesh_route_stage #(.W(PORT_N)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (hdr_valid),
      .in_ready  (hdr_ready),
      .in_data   (port_next),
      .out_valid (sel_valid),
      .out_ready (sel_ready),
      .out_data  (sel_port)
   );
endmodule

// File: rtl/mesh_route_dor_chk.sv
module mesh_route_dor_chk #(
   parameter int MESH_K = 4,
   localparam int CW = (MESH_K < 2) ? 1 : $clog2(MESH_K)
) (
   input logic           clk,
   input logic           rst_n,
   input logic [CW-1:0]  here_x,
   input logic [CW-1:0]  here_y,
   input logic           hdr_valid,
   input logic           hdr_ready,
   input logic [CW-1:0]  dst_x,
   input logic [CW-1:0]  dst_y,
   input logic           sel_valid,
   input logic           sel_ready,
   input logic [4:0]     sel_port
);
   logic take;
   assign take = hdr_valid && hdr_ready;

   a_r1_west: assert property (@(posedge clk) disable iff (!rst_n)
      take && (dst_x < here_x) |=> sel_port == 5'b00001);

   a_r2_east: assert property (@(posedge clk) disable iff (!rst_n)
      take && (dst_x > here_x) |=> sel_port == 5'b00010);

   a_r3_south: assert property (@(posedge clk) disable iff (!rst_n)
      take && (dst_x == here_x) && (dst_y < here_y) |=> sel_port == 5'b00100);

   a_r4_north: assert property (@(posedge clk) disable iff (!rst_n)
      take && (dst_x == here_x) && (dst_y > here_y) |=> sel_port == 5'b01000);

   a_r5_local: assert property (@(posedge clk) disable iff (!rst_n)
      take && (dst_x == here_x) && (dst_y == here_y) |=> sel_port == 5'b10000);

   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> $countones(sel_port) == 1);

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> sel_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && !sel_ready |=> sel_valid && $stable(sel_port));

   a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && !sel_ready |-> !hdr_ready);

   a_r9_open: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid || sel_ready |-> hdr_ready);

   a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_ready && !hdr_valid |=> !sel_valid);
endmodule

bind mesh_route_dor mesh_route_dor_chk #(.MESH_K(MESH_K)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .here_x    (here_x),
   .here_y    (here_y),
   .hdr_valid (hdr_valid),
   .hdr_ready (hdr_ready),
   .dst_x     (dst_x),
   .dst_y     (dst_y),
   .sel_valid (sel_valid),
   .sel_ready (sel_ready),
   .sel_port  (sel_port)
);

// File: tb/mesh_route_dor_bench.sv
`timescale 1ns/1ps
module mesh_route_dor_bench;
   localparam int K  = 4;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] here_x, here_y, dst_x, dst_y;
   logic          hdr_valid, hdr_ready, sel_valid, sel_ready;
   logic [4:0]    sel_port;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   mesh_route_dor #(.MESH_K(K)) u_mesh_route_dor (
      .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .dst_x(dst_x), .dst_y(dst_y),
      .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_port(sel_port)
   );

   task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // X-first expected port: bit0 W, bit1 E, bit2 S, bit3 N, bit4 local.
   function automatic logic [4:0] want(int hx, int hy, int dx, int dy);
      if (dx - hx < 0)      return 5'b00001;
      else if (dx - hx > 0) return 5'b00010;
      else if (dy - hy < 0) return 5'b00100;
      else if (dy - hy > 0) return 5'b01000;
      else                  return 5'b10000;
   endfunction

   function automatic string tag(int hx, int hy, int dx, int dy);
      if (dx < hx)      return "R1 west";
      else if (dx > hx) return "R2 east";
      else if (dy < hy) return "R3 south";
      else if (dy > hy) return "R4 north";
      else              return "R5 local";
   endfunction

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
   end

   initial begin
      rst_n = 0; hdr_valid = 0; sel_ready = 0;
      here_x = 0; here_y = 0; dst_x = 0; dst_y = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 reset", {5'b0, sel_valid}, 6'd0);
      chk("R10 reset ready", {5'b0, hdr_ready}, 6'd1);
      rst_n = 1;

      // Full sweep, back to back, downstream always ready (R7 latency).
      sel_ready = 1;
      for (int hx = 0; hx < K; hx++)
         for (int hy = 0; hy < K; hy++)
            for (int dx = 0; dx < K; dx++)
               for (int dy = 0; dy < K; dy++) begin
                  here_x = CW'(hx); here_y = CW'(hy);
                  dst_x  = CW'(dx); dst_y  = CW'(dy);
                  hdr_valid = 1;
                  @(posedge clk);
                  @(negedge clk);
                  chk("R7 valid after accept", {5'b0, sel_valid}, 6'd1);
                  chk(tag(hx, hy, dx, dy), {1'b0, sel_port}, {1'b0, want(hx, hy, dx, dy)});
                  chk("R6 one-hot", 6'($countones(sel_port)), 6'd1);
               end

      // R11: taken with nothing offered.
      hdr_valid = 0;
      @(posedge clk);
      @(negedge clk);
      chk("R11 drain", {5'b0, sel_valid}, 6'd0);
      chk("R9 idle ready", {5'b0, hdr_ready}, 6'd1);

      // Stall with a second header waiting (R8).
      here_x = 1; here_y = 1; dst_x = 3; dst_y = 1; hdr_valid = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R2 east before stall", {1'b0, sel_port}, 6'b000010);
      sel_ready = 0; dst_x = 1; dst_y = 0;
      #0.5;
      chk("R8 blocked", {5'b0, hdr_ready}, 6'd0);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R8 hold valid", {5'b0, sel_valid}, 6'd1);
         chk("R8 hold port", {1'b0, sel_port}, 6'b000010);
      end
      sel_ready = 1;
      #0.5;
      chk("R9 ready on take", {5'b0, hdr_ready}, 6'd1);
      @(posedge clk);
      @(negedge clk);
      chk("R3 south after stall", {1'b0, sel_port}, 6'b000100);
      hdr_valid = 0; sel_ready = 0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 hold without header", {sel_valid, sel_port}, 6'b100100);
      sel_ready = 1;
      @(posedge clk);
      @(negedge clk);
      chk("R11 drain after stall", {5'b0, sel_valid}, 6'd0);

      report();
   end
endmodule